// File: doc/BRIEF.md
# Power-Fail Memory Write-Protect Controller

This block sits between a host bus and a static memory array and keeps the array safe while the supply is lost. It watches two digitized supply flags. One says the supply is below the power-fail threshold. The other says it is below the lower switchover level.

While the supply is good, the host's active-low chip-enable, write-enable and output-enable strobes pass straight through to the memory. When the power-fail flag rises, a pending phase of a fixed number of clock cycles starts. At the end of it, all strobes are forced inactive and the data bus is released. If the supply recovers during the pending phase, the block returns to normal access with no protection.

Once protected, the block selects the backup source while the switchover flag is high. After the supply returns, it keeps protection on for a long lockout period before host access is restored. Both intervals are parameters counted in clock cycles.

Top module: `pwr_guard`

## Requirements
- R1: While prot_o is low, mem_ce_no, mem_we_no and mem_oe_no equal ce_ni, we_ni and oe_ni in the same cycle. All strobes are active low.
- R2: dq_oe_o is high exactly when prot_o is low, ce_ni is 0, oe_ni is 0 and we_ni is 1.
- R3: From normal operation, after pf_i (active high) is first sampled high, prot_o rises after exactly PROT_DLY_CYC further clock edges with pf_i held high. If pf_i drops before that, prot_o never rises and the block returns to normal.
- R4: While prot_o is high, mem_ce_no, mem_we_no and mem_oe_no are 1 and dq_oe_o is 0, whatever the host strobes are.
- R5: A host write held low across the protection point has mem_we_no forced to 1 in the first cycle in which prot_o is high.
- R6: While protected, bat_sel_o rises on the edge after so_i (active high) is sampled high. It falls on the edge after so_i is sampled low, and prot_o stays high. bat_sel_o is never high while prot_o is low.
- R7: If so_i is high while protection is pending, protection engages at the next edge without waiting for the delay.
- R8: When pf_i is sampled low while protected, prot_o stays high for RECOV_CYC more cycles and then falls.
- R9: If pf_i returns high during the lockout, the block goes back to the protected state. A later lockout then runs the full RECOV_CYC again.
- R10: During and just after the active-low asynchronous reset rst_ni, prot_o and bat_sel_o are 0 and the strobes pass through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pf_i | input | 1 | Supply below power-fail threshold |
| so_i | input | 1 | Supply below switchover level |
| ce_ni | input | 1 | Host chip enable, active low |
| we_ni | input | 1 | Host write enable, active low |
| oe_ni | input | 1 | Host output enable, active low |
| mem_ce_no | output | 1 | Gated chip enable to memory |
| mem_we_no | output | 1 | Gated write enable to memory |
| mem_oe_no | output | 1 | Gated output enable to memory |
| dq_oe_o | output | 1 | Data output drive enable |
| bat_sel_o | output | 1 | Backup source selected |
| prot_o | output | 1 | Write protection active |

## Verification
The delay timer can expire in the same cycle that a host write is still being held low. The bench holds we_ni and ce_ni low through the whole pending phase. It then checks that mem_we_no follows the host until the exact cycle in which prot_o rises, and is high from that cycle on.

The lockout timer can also meet a renewed power failure. The bench raises pf_i partway through the lockout. It then checks that protection holds and that the following lockout lasts the full count, which shows that the counter was cleared.

// File: rtl/pwr_guard_pkg.sv
package pwr_guard_pkg;
  typedef enum logic [2:0] {
    ST_NORMAL  = 3'd0,
    ST_PENDING = 3'd1,
    ST_PROT    = 3'd2,
    ST_BATT    = 3'd3,
    ST_RECOV   = 3'd4
  } pg_state_e;
endpackage

// File: rtl/pwr_guard_timer.sv
module pwr_guard_timer #(
  parameter int unsigned LIMIT = 10,
  localparam int unsigned W = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (!run_i)                  cnt_q <= '0;
    else if (cnt_q != W'(LIMIT - 1))  cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = run_i && (cnt_q == W'(LIMIT - 1));
endmodule

// File: rtl/pwr_guard_fsm.sv
module pwr_guard_fsm
  import pwr_guard_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pf_i,
  input  logic so_i,
  input  logic dly_done_i,
  input  logic rec_done_i,
  output logic dly_run_o,
  output logic rec_run_o,
  output logic prot_o,
  output logic bat_sel_o
);
  pg_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_NORMAL:  if (pf_i) state_d = ST_PENDING;
      ST_PENDING: if (!pf_i) state_d = ST_NORMAL;
                  else if (so_i || dly_done_i) state_d = ST_PROT;
      ST_PROT:    if (so_i) state_d = ST_BATT;
                  else if (!pf_i) state_d = ST_RECOV;
      ST_BATT:    if (!so_i) state_d = ST_PROT;
      ST_RECOV:   if (pf_i) state_d = ST_PROT;  // refail restarts lockout
                  else if (rec_done_i) state_d = ST_NORMAL;
      default:    state_d = ST_PROT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_NORMAL;
    else         state_q <= state_d;
  end

  assign dly_run_o = (state_q == ST_PENDING);
  assign rec_run_o = (state_q == ST_RECOV);
  assign prot_o    = (state_q != ST_NORMAL) && (state_q != ST_PENDING);
  assign bat_sel_o = (state_q == ST_BATT);

  a_r3_rise_needs_pf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(prot_o) |-> $past(pf_i));
  a_r8_fall_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(prot_o) |-> !$past(pf_i));
  a_r6_bat_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bat_sel_o) |-> (!$past(so_i) && prot_o));
endmodule

// File: rtl/pwr_guard_gate.sv
module pwr_guard_gate (
  input  logic prot_i,
  input  logic ce_ni,
  input  logic we_ni,
  input  logic oe_ni,
  output logic mem_ce_no,
  output logic mem_we_no,
  output logic mem_oe_no,
  output logic dq_oe_o
);
  assign mem_ce_no = prot_i | ce_ni;
  assign mem_we_no = prot_i | we_ni;
  assign mem_oe_no = prot_i | oe_ni;
  assign dq_oe_o   = !prot_i && !ce_ni && !oe_ni && we_ni;
endmodule

// File: rtl/pwr_guard.sv
module pwr_guard #(
  parameter int unsigned PROT_DLY_CYC = 10000,
  parameter int unsigned RECOV_CYC    = 8000000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pf_i,
  input  logic so_i,
  input  logic ce_ni,
  input  logic we_ni,
  input  logic oe_ni,
  output logic mem_ce_no,
  output logic mem_we_no,
  output logic mem_oe_no,
  output logic dq_oe_o,
  output logic bat_sel_o,
  output logic prot_o
);
  logic dly_run, rec_run, dly_done, rec_done;

  pwr_guard_timer #(.LIMIT(PROT_DLY_CYC)) u_dly (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(dly_run), .done_o(dly_done));

  pwr_guard_timer #(.LIMIT(RECOV_CYC)) u_rec (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(rec_run), .done_o(rec_done));

  pwr_guard_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .pf_i(pf_i), .so_i(so_i),
    .dly_done_i(dly_done), .rec_done_i(rec_done),
    .dly_run_o(dly_run), .rec_run_o(rec_run),
    .prot_o(prot_o), .bat_sel_o(bat_sel_o));

  pwr_guard_gate u_gate (
    .prot_i(prot_o), .ce_ni(ce_ni), .we_ni(we_ni), .oe_ni(oe_ni),
    .mem_ce_no(mem_ce_no), .mem_we_no(mem_we_no), .mem_oe_no(mem_oe_no),
    .dq_oe_o(dq_oe_o));

  a_r4_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prot_o |-> (mem_ce_no && mem_we_no && mem_oe_no && !dq_oe_o));
  a_r6_bat_in_prot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bat_sel_o |-> prot_o);
  a_r2_drive_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> (!mem_oe_no && !mem_ce_no && mem_we_no));
endmodule

// File: tb/tb_pwr_guard.sv
module tb_pwr_guard;
  localparam int unsigned DLY = 4;
  localparam int unsigned REC = 6;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic pf_i = 1'b0, so_i = 1'b0, ce_ni = 1'b1, we_ni = 1'b1, oe_ni = 1'b1;
  logic mem_ce_no, mem_we_no, mem_oe_no, dq_oe_o, bat_sel_o, prot_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [5:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  pwr_guard #(.PROT_DLY_CYC(DLY), .RECOV_CYC(REC)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .pf_i(pf_i), .so_i(so_i),
    .ce_ni(ce_ni), .we_ni(we_ni), .oe_ni(oe_ni),
    .mem_ce_no(mem_ce_no), .mem_we_no(mem_we_no), .mem_oe_no(mem_oe_no),
    .dq_oe_o(dq_oe_o), .bat_sel_o(bat_sel_o), .prot_o(prot_o));

  // driver: sets inputs after a falling edge and queues the expected outputs
  task automatic cyc(input logic pf, input logic so, input logic ce,
                     input logic we, input logic oe, input logic ep,
                     input logic eb, input string tag);
    logic [5:0] e;
    @(negedge clk);
    pf_i = pf; so_i = so; ce_ni = ce; we_ni = we; oe_ni = oe;
    if (ep) e = {3'b111, 1'b0, eb, 1'b1};
    else    e = {ce, we, oe, (!ce && !oe && we), eb, 1'b0};
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // monitor: compares between edges
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (exp_q.size() > 0) begin
        logic [5:0] a, e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        a = {mem_ce_no, mem_we_no, mem_oe_no, dq_oe_o, bat_sel_o, prot_o};
        checks++;
        if (a !== e) begin
          errors++;
          $display("FAIL %s act=%b exp=%b", t, a, e);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(0,0, 0,1,0, 0,0, "R10 reset read");
    cyc(1,1, 0,0,1, 0,0, "R10 reset ignores flags");
    @(negedge clk); rst_ni = 1'b1;
    cyc(0,0, 0,1,0, 0,0, "R10 after reset");
    // R1 R2 passthrough patterns
    cyc(0,0, 0,0,1, 0,0, "R1 write");
    cyc(0,0, 0,1,0, 0,0, "R2 read");
    cyc(0,0, 0,1,1, 0,0, "R2 oe off");
    cyc(0,0, 1,1,0, 0,0, "R1 deselect");
    cyc(0,0, 0,0,0, 0,0, "R2 write with oe");
    // R3 abort in pending
    for (int i = 0; i < 3; i++) cyc(1,0, 0,1,0, 0,0, "R3 pending");
    cyc(0,0, 0,1,0, 0,0, "R3 abort");
    for (int i = 0; i < DLY + 2; i++) cyc(0,0, 0,1,0, 0,0, "R3 no protect");
    // R3 R5 full delay with a write in flight
    for (int i = 0; i < DLY + 1; i++) cyc(1,0, 0,0,1, 0,0, "R3 delay");
    cyc(1,0, 0,0,1, 1,0, "R5 write cut");
    // R4 host ignored
    cyc(1,0, 0,1,0, 1,0, "R4 read blocked");
    cyc(1,0, 0,0,0, 1,0, "R4 write blocked");
    // R6 battery
    cyc(1,1, 0,1,0, 1,0, "R6 before switch");
    cyc(1,1, 0,0,1, 1,1, "R6 battery");
    cyc(1,1, 0,1,0, 1,1, "R6 battery hold");
    cyc(1,0, 0,1,0, 1,1, "R6 release sample");
    cyc(1,0, 0,1,0, 1,0, "R6 back to protect");
    // R9 refail during lockout
    for (int i = 0; i < 3; i++) cyc(0,0, 0,1,0, 1,0, "R9 lockout");
    cyc(1,0, 0,1,0, 1,0, "R9 refail");
    cyc(1,0, 0,1,0, 1,0, "R9 protected");
    // R8 full lockout
    for (int i = 0; i < REC + 1; i++) cyc(0,0, 0,1,0, 1,0, "R8 lockout");
    cyc(0,0, 0,1,0, 0,0, "R8 resume read");
    cyc(0,0, 0,0,1, 0,0, "R8 resume write");
    // R7 switchover during pending
    cyc(1,1, 1,1,1, 0,0, "R7 normal");
    cyc(1,1, 1,1,1, 0,0, "R7 pending");
    cyc(1,1, 1,1,1, 1,0, "R7 early protect");
    cyc(1,1, 1,1,1, 1,1, "R7 battery");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule